// File: doc/BRIEF.md
# Traffic-Class Mapper and Virtual-Channel Arbiter

This block serves a single egress port. Every packet that arrives for the port carries a 3-bit traffic class. A programmable table, held inside the block, turns that class into the index of one of up to four virtual-channel queues. Any number of classes may share one channel, and the build may have fewer channels than classes.

On the output side, each channel queue raises a request while it holds a packet. The arbiter picks one requesting channel and grants it the link with a registered one-hot grant. It keeps that grant until the chosen channel signals the last beat of its packet, then chooses again. Three policies are available: fixed priority, round robin, and weighted round robin. The weighted policy walks a programmable table of channel indices whose active length is 32, 64, 128 or 256 phases.

Top module: `tcvc_arb`

## Requirements
- R1: `vc_out` is a combinational lookup of the class map: class k selects the map entry at bits [2k+1:2k] of the map register.
- R2: After reset the map sends classes 0, 1 and 2 to channel 0 and classes 3 to 7 to channel 1 (map register 16'h5540).
- R3: With `map_we` high at a clock edge, the map register loads `map_wdata`, and several classes may then share one channel. With `map_we` low, `map_wdata` has no effect on `vc_out`.
- R4: `gnt` is one-hot or zero. It is zero in reset and while no channel requests. When the arbiter is idle at a clock edge and some channel requests, `gnt` shows the winner from that edge on, and the winner is always a channel whose request was high at that edge.
- R5: A grant stays unchanged until `eop` of the granted channel is high at a clock edge. `eop` of other channels is ignored. After the release `gnt` is zero for one cycle, and the next choice is made at the following edge.
- R6: In fixed-priority mode (`mode` 0, and the reserved code 3) the highest-numbered requesting channel wins.
- R7: In round-robin mode (`mode` 1) the search starts at the channel after the one granted last, in any mode, and wraps around. The last-granted channel resets to channel 3.
- R8: In weighted mode (`mode` 2) entry i of `wrr_tbl` is the channel index at bits [2i+1:2i]. A pointer resets to 0. The grant goes to the channel of the first entry, at or after the pointer and wrapping within the active length, whose channel requests. The pointer then moves to the entry after the one used. Other modes leave the pointer alone.
- R9: `tbl_len_sel` values 0, 1, 2 and 3 give active lengths of 32, 64, 128 and 256 entries. Entries beyond the active length are never used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| map_we | input | 1 | Load strobe for the class map |
| map_wdata | input | 16 | New class map, 2 bits per class |
| cls_in | input | 3 | Traffic class of the incoming packet |
| vc_out | output | 2 | Channel index for that packet |
| mode | input | 2 | Arbitration policy: 0 fixed, 1 round robin, 2 weighted, 3 fixed |
| tbl_len_sel | input | 2 | Weighted table length: 32 << value |
| wrr_tbl | input | 512 | Weighted table, 256 entries of 2 bits |
| req | input | 4 | Per-channel packet pending |
| eop | input | 4 | Per-channel last beat of packet |
| gnt | output | 4 | One-hot grant |

## Verification
Fixed priority is driven with sparse and dense request sets, so a lowest-first or stuck choice gives a different winner. Round robin runs long streams with every channel requesting and then with gaps, which shows whether the rotation pointer moves and whether it skips idle channels. The weighted mode first uses a 32-entry window whose entries name only channels 0 and 3, then a 64-entry window that reaches entries naming channel 1, so a wrong length mask or a wrong wrap shows up in the grant order. A single-requester stream shows the skip over non-requesting entries. The map is read back after reset, after a many-to-one load, and after a write with the strobe low.

// File: rtl/tcvc_pkg.sv
package tcvc_pkg;

    localparam int NUM_TC = 8;
    localparam int TC_W   = 3;

    typedef enum logic [1:0] {
        ARB_FIXED = 2'd0,
        ARB_RR    = 2'd1,
        ARB_WRR   = 2'd2,
        ARB_RSVD  = 2'd3
    } arb_mode_e;

endpackage

// File: rtl/tcvc_map.sv
module tcvc_map
    import tcvc_pkg::*;
#(
    parameter int NUM_VC = 4,
    parameter int VC_W   = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   map_we,
    input  logic [NUM_TC*VC_W-1:0] map_wdata,
    input  logic [TC_W-1:0]        cls_in,
    output logic [VC_W-1:0]        vc_out
);

    localparam int MAP_W = NUM_TC * VC_W;

    function automatic logic [MAP_W-1:0] reset_map();
        logic [MAP_W-1:0] m;
        m = '0;
        for (int k = 3; k < NUM_TC; k++) begin
            m[k*VC_W +: VC_W] = (NUM_VC > 1) ? VC_W'(1) : VC_W'(0);
        end
        return m;
    endfunction

    localparam logic [MAP_W-1:0] MAP_RST = reset_map();

    typedef struct packed {
        logic [MAP_W-1:0] map;
    } map_state_t;

    map_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (map_we) begin
            s_d.map = map_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.map <= MAP_RST;
        end else begin
            s_q <= s_d;
        end
    end

    logic [VC_W-1:0] entry [NUM_TC];

    for (genvar g = 0; g < NUM_TC; g++) begin : g_entry
        assign entry[g] = s_q.map[g*VC_W +: VC_W];
    end

    assign vc_out = entry[cls_in];

    // R1: lookup changes only when the class or the map changes
    a_r1_lookup_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(cls_in) && !$past(map_we)) |-> $stable(vc_out));

    // R3: a load takes the written value
    a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
        map_we |=> (vc_out == $past(map_wdata[cls_in*VC_W +: VC_W]) || !$stable(cls_in)));

endmodule

// File: rtl/tcvc_wrr_scan.sv
module tcvc_wrr_scan #(
    parameter int NUM_VC  = 4,
    parameter int VC_W    = 2,
    parameter int TBL_MAX = 256,
    parameter int PTR_W   = 8
) (
    input  logic [TBL_MAX*VC_W-1:0] tbl,
    input  logic [PTR_W-1:0]        mask,
    input  logic [PTR_W-1:0]        ptr,
    input  logic [NUM_VC-1:0]       req,
    output logic                    hit,
    output logic [PTR_W-1:0]        hit_idx,
    output logic [VC_W-1:0]         hit_vc
);

    localparam int PAD = 1 << VC_W;

    logic [PAD-1:0]   req_pad;
    logic [PTR_W-1:0] pos;
    logic [VC_W-1:0]  ent;

    always_comb begin
        req_pad = '0;
        req_pad[NUM_VC-1:0] = req;
        hit     = 1'b0;
        hit_idx = '0;
        hit_vc  = '0;
        pos     = '0;
        ent     = '0;
        for (int off = 0; off < TBL_MAX; off++) begin
            pos = (ptr + PTR_W'(off)) & mask;
            ent = tbl[pos*VC_W +: VC_W];
            if (!hit && req_pad[ent]) begin
                hit     = 1'b1;
                hit_idx = pos;
                hit_vc  = ent;
            end
        end
    end

endmodule

// File: rtl/tcvc_pick.sv
module tcvc_pick
    import tcvc_pkg::*;
#(
    parameter int NUM_VC = 4,
    parameter int VC_W   = 2
) (
    input  arb_mode_e           mode,
    input  logic [NUM_VC-1:0]   req,
    input  logic [VC_W-1:0]     last,
    input  logic                wrr_hit,
    input  logic [VC_W-1:0]     wrr_vc,
    output logic                win_valid,
    output logic [VC_W-1:0]     win_idx
);

    int c;

    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        c         = 0;
        unique case (mode)
            ARB_RR: begin
                for (int k = 1; k <= NUM_VC; k++) begin
                    c = (int'(last) + k) % NUM_VC;
                    if (!win_valid && req[c]) begin
                        win_valid = 1'b1;
                        win_idx   = VC_W'(c);
                    end
                end
            end
            ARB_WRR: begin
                win_valid = wrr_hit;
                win_idx   = wrr_vc;
            end
            default: begin
                for (int k = 0; k < NUM_VC; k++) begin
                    if (req[k]) begin
                        win_valid = 1'b1;
                        win_idx   = VC_W'(k);
                    end
                end
            end
        endcase
    end

endmodule

// File: rtl/tcvc_arb.sv
module tcvc_arb
    import tcvc_pkg::*;
#(
    parameter int NUM_VC  = 4,
    parameter int TBL_MAX = 256
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          map_we,
    input  logic [NUM_TC*((NUM_VC > 1) ? $clog2(NUM_VC) : 1)-1:0]  map_wdata,
    input  logic [TC_W-1:0]                               cls_in,
    output logic [((NUM_VC > 1) ? $clog2(NUM_VC) : 1)-1:0] vc_out,
    input  logic [1:0]                                    mode,
    input  logic [1:0]                                    tbl_len_sel,
    input  logic [TBL_MAX*((NUM_VC > 1) ? $clog2(NUM_VC) : 1)-1:0] wrr_tbl,
    input  logic [NUM_VC-1:0]                             req,
    input  logic [NUM_VC-1:0]                             eop,
    output logic [NUM_VC-1:0]                             gnt
);

    localparam int VC_W  = (NUM_VC > 1) ? $clog2(NUM_VC) : 1;
    localparam int PTR_W = $clog2(TBL_MAX);

    typedef struct packed {
        logic [NUM_VC-1:0] gnt;
        logic [VC_W-1:0]   last;
        logic [PTR_W-1:0]  ptr;
    } arb_state_t;

    arb_state_t s_d, s_q;

    arb_mode_e        mode_e;
    logic [PTR_W-1:0] len_mask;
    logic             wrr_hit;
    logic [PTR_W-1:0] wrr_idx;
    logic [VC_W-1:0]  wrr_vc;
    logic             win_valid;
    logic [VC_W-1:0]  win_idx;

    assign mode_e   = arb_mode_e'(mode);
    assign len_mask = PTR_W'((32 << tbl_len_sel) - 1);

    tcvc_map #(.NUM_VC(NUM_VC), .VC_W(VC_W)) i_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .map_we    (map_we),
        .map_wdata (map_wdata),
        .cls_in    (cls_in),
        .vc_out    (vc_out)
    );

    tcvc_wrr_scan #(.NUM_VC(NUM_VC), .VC_W(VC_W), .TBL_MAX(TBL_MAX), .PTR_W(PTR_W)) i_scan (
        .tbl     (wrr_tbl),
        .mask    (len_mask),
        .ptr     (s_q.ptr),
        .req     (req),
        .hit     (wrr_hit),
        .hit_idx (wrr_idx),
        .hit_vc  (wrr_vc)
    );

    tcvc_pick #(.NUM_VC(NUM_VC), .VC_W(VC_W)) i_pick (
        .mode      (mode_e),
        .req       (req),
        .last      (s_q.last),
        .wrr_hit   (wrr_hit),
        .wrr_vc    (wrr_vc),
        .win_valid (win_valid),
        .win_idx   (win_idx)
    );

    always_comb begin
        s_d = s_q;
        if (s_q.gnt == '0) begin
            if (win_valid) begin
                s_d.gnt  = NUM_VC'(1) << win_idx;
                s_d.last = win_idx;
                if (mode_e == ARB_WRR) begin
                    s_d.ptr = (wrr_idx + PTR_W'(1)) & len_mask;
                end
            end
        end else if ((s_q.gnt & eop) != '0) begin
            s_d.gnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.gnt  <= '0;
            s_q.last <= VC_W'(NUM_VC - 1);
            s_q.ptr  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign gnt = s_q.gnt;

    // R4: never more than one channel granted
    a_r4_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    // R4: a fresh grant goes to a channel that was requesting
    a_r4_to_requester: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt == '0) |=> (gnt == '0 || (gnt & $past(req)) != '0));

    // R5: grant held until the granted channel ends its packet
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt != '0 && (gnt & eop) == '0) |=> (gnt == $past(gnt)));

    // R5: end of packet releases the link for one cycle
    a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt & eop) != '0) |=> (gnt == '0));

    // R6: in fixed mode no requester above the winner
    a_r6_fixed_top: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt == '0 && (mode == 2'd0 || mode == 2'd3)) |=>
        (gnt == '0 || (~(gnt | (gnt - NUM_VC'(1))) & $past(req)) == '0));

endmodule

// File: tb/test_tcvc_arb.sv
module test_tcvc_arb;
    import tcvc_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 4;
    localparam int VW = 2;
    localparam int TM = 256;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic           map_we = 1'b0;
    logic [15:0]    map_wdata = '0;
    logic [2:0]     cls_in = '0;
    logic [1:0]     vc_out;
    logic [1:0]     mode = 2'd0;
    logic [1:0]     tbl_len_sel = 2'd0;
    logic [TM*VW-1:0] wrr_tbl = '0;
    logic [NV-1:0]  req = '0;
    logic [NV-1:0]  eop = '0;
    logic [NV-1:0]  gnt;

    tcvc_arb i_tcvc_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .map_we      (map_we),
        .map_wdata   (map_wdata),
        .cls_in      (cls_in),
        .vc_out      (vc_out),
        .mode        (mode),
        .tbl_len_sel (tbl_len_sel),
        .wrr_tbl     (wrr_tbl),
        .req         (req),
        .eop         (eop),
        .gnt         (gnt)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        int    vc;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    exp_t mon_e;

    int m_last = NV - 1;
    int m_ptr  = 0;

    task automatic check(bit ok, string rtag, string what, longint act, longint expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rtag, what, act, expv);
        end
    endtask

    function automatic int model_pick(logic [NV-1:0] r);
        int w;
        int len;
        int c;
        int pos;
        int e;
        w   = -1;
        len = 32 << tbl_len_sel;
        if (len > TM) len = TM;
        case (mode)
            2'd1: begin
                for (int k = 1; k <= NV; k++) begin
                    c = (m_last + k) % NV;
                    if (w < 0 && r[c]) w = c;
                end
            end
            2'd2: begin
                for (int off = 0; off < len; off++) begin
                    pos = (m_ptr + off) % len;
                    e   = int'(wrr_tbl[pos*VW +: VW]);
                    if (w < 0 && r[e]) begin
                        w     = e;
                        m_ptr = (pos + 1) % len;
                    end
                end
            end
            default: begin
                for (int k = 0; k < NV; k++) begin
                    if (r[k]) w = k;
                end
            end
        endcase
        if (w >= 0) m_last = w;
        return w;
    endfunction

    // monitor: compares each fresh grant with the scoreboard head
    logic [NV-1:0] prev_g = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (gnt != '0 && prev_g == '0) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4", "unexpected grant", longint'(gnt), 0);
                end else begin
                    mon_e = exp_q.pop_front();
                    check(gnt == (NV'(1) << mon_e.vc), mon_e.tag, "granted channel",
                          longint'(gnt), longint'(1) << mon_e.vc);
                end
            end
        end
        prev_g = gnt;
    end

    task automatic run_pkt(logic [NV-1:0] r, string tag);
        exp_t e;
        bit got;
        logic [NV-1:0] g;
        e.vc  = model_pick(r);
        e.tag = tag;
        exp_q.push_back(e);
        req = r;
        got = 1'b0;
        for (int i = 0; i < 40 && !got; i++) begin
            @(negedge clk);
            if (gnt != '0) got = 1'b1;
        end
        check(got, tag, "grant appears", longint'(gnt), 1);
        if (!got) begin
            req = '0;
            void'(exp_q.pop_front());
            return;
        end
        g = gnt;
        @(negedge clk);
        check(gnt == g, "R5", "grant held", longint'(gnt), longint'(g));
        eop = ~g;
        @(negedge clk);
        eop = '0;
        check(gnt == g, "R5", "other eop ignored", longint'(gnt), longint'(g));
        eop = g;
        @(negedge clk);
        eop = '0;
        check(gnt == '0, "R5", "released after eop", longint'(gnt), 0);
    endtask

    task automatic chk_map(int c, int expv, string tag);
        cls_in = 3'(c);
        #1;
        check(int'(vc_out) == expv, tag, $sformatf("class %0d map", c), longint'(vc_out), expv);
    endtask

    logic [15:0] new_map;

    initial begin
        for (int i = 0; i < TM; i++) begin
            if (i < 32) wrr_tbl[i*VW +: VW] = (i % 2 == 0) ? 2'd0 : 2'd3;
            else        wrr_tbl[i*VW +: VW] = 2'd1;
        end
        repeat (3) @(negedge clk);
        check(gnt == '0, "R4", "grant in reset", longint'(gnt), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: reset map
        for (int c = 0; c < 8; c++) chk_map(c, (c < 3) ? 0 : 1, "R2");

        // R4: no requests, no grant
        repeat (3) @(negedge clk);
        check(gnt == '0, "R4", "idle without requests", longint'(gnt), 0);

        // R6: fixed priority
        mode = 2'd0;
        run_pkt(4'b0101, "R6");
        run_pkt(4'b1111, "R6");
        run_pkt(4'b0001, "R6");
        run_pkt(4'b0110, "R6");
        mode = 2'd3;
        run_pkt(4'b0011, "R6");

        // R7: round robin
        mode = 2'd1;
        for (int i = 0; i < 6; i++) run_pkt(4'b1111, "R7");
        run_pkt(4'b1010, "R7");
        run_pkt(4'b1010, "R7");
        run_pkt(4'b1001, "R7");
        run_pkt(4'b0100, "R7");

        // R8 / R9: weighted table
        mode = 2'd2;
        tbl_len_sel = 2'd0;
        for (int i = 0; i < 40; i++) run_pkt(4'b1111, "R9");
        for (int i = 0; i < 6; i++) run_pkt(4'b0001, "R8");
        tbl_len_sel = 2'd1;
        for (int i = 0; i < 40; i++) run_pkt(4'b1111, "R9");
        tbl_len_sel = 2'd3;
        for (int i = 0; i < 10; i++) run_pkt(4'b0110, "R8");
        req = '0;
        repeat (2) @(negedge clk);

        // R3 / R1: many-to-one map load
        new_map = '0;
        for (int c = 0; c < 8; c++) new_map[c*2 +: 2] = (c == 5) ? 2'd2 : 2'd3;
        map_wdata = new_map;
        map_we = 1'b1;
        @(negedge clk);
        map_we = 1'b0;
        for (int c = 0; c < 8; c++) chk_map(c, (c == 5) ? 2 : 3, "R3");
        map_wdata = 16'h1b1b;
        repeat (2) @(negedge clk);
        for (int c = 0; c < 8; c++) chk_map(c, (c == 5) ? 2 : 3, "R1");

        check(exp_q.size() == 0, "R4", "all expected grants seen", exp_q.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL R4 watchdog expired: actual 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule